// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 SDRAM interface. It takes the memory device from power-up to a state where normal traffic can begin. A one-cycle `start` pulse launches a fixed bring-up program. The program holds the memory reset pin low, releases it, and raises clock enable after a settling interval. It then loads the four mode registers from the values on its configuration inputs, issues a long ZQ calibration, waits out DLL lock and ZQ initialisation, and then raises `init_done`.

Every wait is a parameter counted in clock cycles. The defaults suit a 200 MHz clock, and a bench can shrink them. The sequencer drives a no-operation command on every cycle that carries no mode-register or calibration command. It keeps on-die termination off throughout. A new `start` at any time, including after completion, aborts whatever is in progress and reruns the program from the reset-hold step.

Top module: `ddr3_init_seq`

## Requirements
- R1: After `rst_n` and before any `start`, `mem_rst_n`=0, `mem_cke`=0, `init_done`=0, and the bus carries NOP, encoded as {cs_n,ras_n,cas_n,we_n}=0111.
- R2: `mem_rst_n` stays 0 for T_RST_HOLD cycles, counted from the first cycle after `start` is sampled, and then goes to 1.
- R3: `mem_cke` is 0 whenever `mem_rst_n` is 0. It rises max(T_CKE_WAIT,5) cycles after `mem_rst_n` rises, and the bus shows NOP in that first CKE-high cycle.
- R4: Once `mem_cke` is 1, it stays 1 until the next `start`.
- R5: `mem_odt` is 0 in every cycle.
- R6: The first mode-register write comes max(T_XS,5) cycles after the CKE rise, encoded as {cs_n,ras_n,cas_n,we_n}=0000. No command is issued while `mem_cke` is 0.
- R7: Mode-register writes go to BA=2, BA=3, BA=1 and BA=0, in that order, T_MRD cycles apart. For BA=2 and BA=3, `mem_addr` equals the matching configuration input.
- R8: The BA=1 write carries `mr1_cfg` with bit 0 forced to 0 (DLL on). The BA=0 write carries `mr0_cfg` with bit 8 forced to 1 (DLL reset).
- R9: T_MOD cycles after the BA=0 write, a long ZQ calibration is issued. It is encoded as {cs_n,ras_n,cas_n,we_n}=0110, with `mem_addr` bit 10 set, all other address bits 0, and BA=0.
- R10: `init_done` rises max(T_DLLK,T_ZQINIT) cycles after the calibration command and stays high until the next `start`. Every cycle that carries no write or calibration command carries NOP.
- R11: In the cycle after `start` is sampled, in any state, `mem_rst_n`, `mem_cke` and `init_done` are all 0, and the whole program runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that launches or relaunches the program |
| mr0_cfg | input | ADDR_W | Application value for mode register 0 |
| mr1_cfg | input | ADDR_W | Application value for mode register 1 |
| mr2_cfg | input | ADDR_W | Application value for mode register 2 |
| mr3_cfg | input | ADDR_W | Application value for mode register 3 |
| mem_rst_n | output | 1 | Memory reset pin, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_odt | output | 1 | On-die termination control, held low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once the device is ready |

## Verification
Every result is due a fixed number of cycles after the edge that samples `start`. Call the first cycle after that edge s. Reset rises at s+T_RST_HOLD. CKE follows after the effective wait. The four writes fall at c1, c1+T_MRD, c1+2·T_MRD and c1+3·T_MRD, with c1 the CKE rise plus the effective tXPR. Calibration comes T_MOD later, and done rises the effective final wait after that. The driver computes each of these absolute cycle numbers when it launches the sequence and queues them. The monitor samples the pins at the falling edge, stamps each edge or command it sees with the rising-edge count, and compares the stamp with the head of the queue. An early, late, extra or missing event is therefore reported.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_CKE_WAIT,
    ST_XPR_WAIT,
    ST_MRS_CMD,
    ST_MRS_GAP,
    ST_MOD_GAP,
    ST_ZQ_CMD,
    ST_FINAL_WAIT,
    ST_READY
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_MRS,
    CMD_ZQCL
  } bus_cmd_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr3_init_rst_sync.sv
module ddr3_init_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // A load wins; otherwise count down to zero and rest there.
  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr3_init_cmd_enc.sv
module ddr3_init_cmd_enc
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  bus_cmd_e          cmd,
  input  logic [2:0]        ba_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [2:0]        ba_out,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int unsigned ZQ_LONG_BIT = 10;

  always_comb begin
    cs_n     = 1'b0;
    ras_n    = 1'b1;
    cas_n    = 1'b1;
    we_n     = 1'b1;
    ba_out   = '0;
    addr_out = '0;
    unique case (cmd)
      CMD_MRS: begin
        ras_n    = 1'b0;
        cas_n    = 1'b0;
        we_n     = 1'b0;
        ba_out   = ba_in;
        addr_out = addr_in;
      end
      CMD_ZQCL: begin
        we_n                  = 1'b0;
        addr_out[ZQ_LONG_BIT] = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned T_RST_HOLD = 40000,
  parameter int unsigned T_CKE_WAIT = 100000,
  parameter int unsigned T_XS       = 24,
  parameter int unsigned T_MRD      = 4,
  parameter int unsigned T_MOD      = 12,
  parameter int unsigned T_DLLK     = 512,
  parameter int unsigned T_ZQINIT   = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] mr0_cfg,
  input  logic [ADDR_W-1:0] mr1_cfg,
  input  logic [ADDR_W-1:0] mr2_cfg,
  input  logic [ADDR_W-1:0] mr3_cfg,
  output logic              mem_rst_n,
  output logic              mem_cke,
  output logic              mem_odt,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [2:0]        mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  // Effective interval lengths, clamped to the minimum each step needs.
  localparam int unsigned RST_CYC  = max2(T_RST_HOLD, 1);
  localparam int unsigned CKEW_CYC = max2(T_CKE_WAIT, 5);
  localparam int unsigned XPR_CYC  = max2(T_XS, 5);
  localparam int unsigned MRD_CYC  = max2(T_MRD, 2);
  localparam int unsigned MOD_CYC  = max2(T_MOD, 2);
  localparam int unsigned FIN_CYC  = max2(max2(T_DLLK, T_ZQINIT), 2);
  localparam int unsigned LONGEST  = max2(max2(RST_CYC, CKEW_CYC), max2(XPR_CYC, FIN_CYC));
  localparam int unsigned CNT_W    = $clog2(LONGEST + 1);

  // Timer load values: a state that lasts N cycles loads N-1. A gap that
  // follows a one-cycle command loads N-2, so command-to-command is N.
  localparam logic [CNT_W-1:0] LD_RST  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CKEW = CNT_W'(CKEW_CYC - 1);
  localparam logic [CNT_W-1:0] LD_XPR  = CNT_W'(XPR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(MRD_CYC - 2);
  localparam logic [CNT_W-1:0] LD_MOD  = CNT_W'(MOD_CYC - 2);
  localparam logic [CNT_W-1:0] LD_FIN  = CNT_W'(FIN_CYC - 2);

  localparam int unsigned DLL_ON_BIT  = 0;
  localparam int unsigned DLL_RST_BIT = 8;

  logic              rst_sync_n;
  seq_state_e        state_q;
  seq_state_e        state_d;
  logic [1:0]        mr_idx_q;
  logic [1:0]        mr_idx_d;
  logic              mr_idx_en;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  bus_cmd_e          cur_cmd;
  logic [2:0]        mr_ba;
  logic [ADDR_W-1:0] mr_data;

  ddr3_init_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ddr3_init_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  // Next-state logic. A start pulse overrides every state.
  always_comb begin
    state_d   = state_q;
    mr_idx_d  = mr_idx_q;
    mr_idx_en = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    if (start) begin
      state_d   = ST_RST_HOLD;
      mr_idx_d  = '0;
      mr_idx_en = 1'b1;
      tmr_load  = 1'b1;
      tmr_val   = LD_RST;
    end else begin
      unique case (state_q)
        ST_RST_HOLD: if (tmr_exp) begin
          state_d  = ST_CKE_WAIT;
          tmr_load = 1'b1;
          tmr_val  = LD_CKEW;
        end
        ST_CKE_WAIT: if (tmr_exp) begin
          state_d  = ST_XPR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = LD_XPR;
        end
        ST_XPR_WAIT: if (tmr_exp) begin
          state_d   = ST_MRS_CMD;
          mr_idx_d  = '0;
          mr_idx_en = 1'b1;
        end
        ST_MRS_CMD: begin
          tmr_load = 1'b1;
          if (mr_idx_q == 2'd3) begin
            state_d = ST_MOD_GAP;
            tmr_val = LD_MOD;
          end else begin
            state_d = ST_MRS_GAP;
            tmr_val = LD_MRD;
          end
        end
        ST_MRS_GAP: if (tmr_exp) begin
          state_d   = ST_MRS_CMD;
          mr_idx_d  = mr_idx_q + 2'd1;
          mr_idx_en = 1'b1;
        end
        ST_MOD_GAP: if (tmr_exp) begin
          state_d = ST_ZQ_CMD;
        end
        ST_ZQ_CMD: begin
          state_d  = ST_FINAL_WAIT;
          tmr_load = 1'b1;
          tmr_val  = LD_FIN;
        end
        ST_FINAL_WAIT: if (tmr_exp) begin
          state_d = ST_READY;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mr_idx_q <= '0;
    end else if (mr_idx_en) begin
      mr_idx_q <= mr_idx_d;
    end
  end

  // Mode-register write order and forced DLL bits.
  always_comb begin
    mr_ba   = 3'd0;
    mr_data = mr0_cfg;
    unique case (mr_idx_q)
      2'd0: begin
        mr_ba   = 3'd2;
        mr_data = mr2_cfg;
      end
      2'd1: begin
        mr_ba   = 3'd3;
        mr_data = mr3_cfg;
      end
      2'd2: begin
        mr_ba               = 3'd1;
        mr_data             = mr1_cfg;
        mr_data[DLL_ON_BIT] = 1'b0;
      end
      default: begin
        mr_ba                = 3'd0;
        mr_data              = mr0_cfg;
        mr_data[DLL_RST_BIT] = 1'b1;
      end
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_MRS_CMD: cur_cmd = CMD_MRS;
      ST_ZQ_CMD:  cur_cmd = CMD_ZQCL;
      default:    cur_cmd = CMD_NOP;
    endcase
  end

  ddr3_init_cmd_enc #(
    .ADDR_W (ADDR_W)
  ) u_cmd_enc (
    .cmd      (cur_cmd),
    .ba_in    (mr_ba),
    .addr_in  (mr_data),
    .cs_n     (mem_cs_n),
    .ras_n    (mem_ras_n),
    .cas_n    (mem_cas_n),
    .we_n     (mem_we_n),
    .ba_out   (mem_ba),
    .addr_out (mem_addr)
  );

  assign mem_rst_n = !((state_q == ST_IDLE) || (state_q == ST_RST_HOLD));
  assign mem_cke   = !((state_q == ST_IDLE) || (state_q == ST_RST_HOLD) ||
                       (state_q == ST_CKE_WAIT));
  assign mem_odt   = 1'b0;
  assign init_done = (state_q == ST_READY);

endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       mem_rst_n,
  input logic       mem_cke,
  input logic       mem_odt,
  input logic       mem_cs_n,
  input logic       mem_ras_n,
  input logic       mem_cas_n,
  input logic       mem_we_n,
  input logic [2:0] mem_ba,
  input logic       a0,
  input logic       a8,
  input logic       a10,
  input logic       init_done
);

  logic is_nop;
  logic is_mrs;
  logic is_zq;

  assign is_nop = !mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n;
  assign is_mrs = !mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n;
  assign is_zq  = !mem_cs_n && mem_ras_n && mem_cas_n && !mem_we_n;

  AST_CKE_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |-> mem_rst_n); // R3
  AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> is_nop); // R3
  AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cke && !start) |=> mem_cke); // R4
  AST_ODT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_odt); // R5
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> mem_cke); // R6
  AST_MR1_DLL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mem_ba == 3'd1) |-> !a0); // R8
  AST_MR0_DLL_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mem_ba == 3'd0) |-> a8); // R8
  AST_ZQ_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    is_zq |-> (a10 && mem_ba == 3'd0)); // R9
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !start) |=> init_done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop); // R10
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!mem_rst_n && !mem_cke && !init_done)); // R11

endmodule

bind ddr3_init_seq ddr3_init_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .mem_rst_n (mem_rst_n),
  .mem_cke   (mem_cke),
  .mem_odt   (mem_odt),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .mem_ba    (mem_ba),
  .a0        (mem_addr[0]),
  .a8        (mem_addr[8]),
  .a10       (mem_addr[10]),
  .init_done (init_done)
);

// File: tb/ddr3_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb_top;

  localparam int P_RST  = 20;
  localparam int P_CKEW = 8;
  localparam int P_XS   = 6;
  localparam int P_MRD  = 4;
  localparam int P_MOD  = 6;
  localparam int P_DLLK = 30;
  localparam int P_ZQI  = 40;
  localparam int E_XPR  = (P_XS > 5) ? P_XS : 5;
  localparam int E_CKEW = (P_CKEW > 5) ? P_CKEW : 5;
  localparam int E_FIN  = (P_DLLK > P_ZQI) ? P_DLLK : P_ZQI;

  localparam int EV_RST_RISE  = 0;
  localparam int EV_RST_FALL  = 1;
  localparam int EV_CKE_RISE  = 2;
  localparam int EV_CKE_FALL  = 3;
  localparam int EV_MRS       = 4;
  localparam int EV_ZQ        = 5;
  localparam int EV_DONE_RISE = 6;
  localparam int EV_DONE_FALL = 7;

  typedef struct {
    int          kind;
    longint      cyc;
    logic [2:0]  ba;
    logic [15:0] addr;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mr0_cfg = '0;
  logic [15:0] mr1_cfg = '0;
  logic [15:0] mr2_cfg = '0;
  logic [15:0] mr3_cfg = '0;
  logic        mem_rst_n, mem_cke, mem_odt;
  logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [2:0]  mem_ba;
  logic [15:0] mem_addr;
  logic        init_done;

  longint n_checks = 0;
  longint n_errors = 0;
  longint cyc = 0;
  bit     mon_en = 1'b0;
  bit     odt_bad = 1'b0;
  bit     finished = 1'b0;
  logic   p_rst, p_cke, p_done;
  exp_t   exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr3_init_seq #(
    .ADDR_W(16), .T_RST_HOLD(P_RST), .T_CKE_WAIT(P_CKEW), .T_XS(P_XS),
    .T_MRD(P_MRD), .T_MOD(P_MOD), .T_DLLK(P_DLLK), .T_ZQINIT(P_ZQI)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mr0_cfg(mr0_cfg), .mr1_cfg(mr1_cfg), .mr2_cfg(mr2_cfg), .mr3_cfg(mr3_cfg),
    .mem_rst_n(mem_rst_n), .mem_cke(mem_cke), .mem_odt(mem_odt),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
    .init_done(init_done)
  );

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endfunction

  function automatic void push(input int k, input longint c, input logic [2:0] b,
                               input logic [15:0] a, input string r);
    exp_t e;
    e.kind = k; e.cyc = c; e.ba = b; e.addr = a; e.req = r;
    exp_q.push_back(e);
  endfunction

  function automatic void observe(input int k, input logic [2:0] b, input logic [15:0] a);
    exp_t e;
    bit   ok;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_errors++;
      $display("FAIL R10 unexpected event: actual kind %0d cyc %0d ba %0d addr %h expected none",
               k, cyc, b, a);
      return;
    end
    e  = exp_q.pop_front();
    ok = (e.kind == k) && (e.cyc == cyc);
    if (k == EV_MRS || k == EV_ZQ) ok = ok && (e.ba == b) && (e.addr == a);
    if (!ok) begin
      n_errors++;
      $display("FAIL %s event: actual kind %0d cyc %0d ba %0d addr %h expected kind %0d cyc %0d ba %0d addr %h",
               e.req, k, cyc, b, a, e.kind, e.cyc, e.ba, e.addr);
    end
  endfunction

  // Monitor: samples at the falling edge, stamps events with the rising-edge count.
  always @(negedge clk) begin
    if (mon_en) begin
      if (mem_odt !== 1'b0) odt_bad = 1'b1;
      if (mem_rst_n !== p_rst) observe(mem_rst_n ? EV_RST_RISE : EV_RST_FALL, 3'd0, 16'h0);
      if (mem_cke !== p_cke) begin
        observe(mem_cke ? EV_CKE_RISE : EV_CKE_FALL, 3'd0, 16'h0);
        if (mem_cke)
          chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111, "R3",
              "bus at CKE rise", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'b0111);
      end
      if ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0000)
        observe(EV_MRS, mem_ba, mem_addr);
      else if ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0110)
        observe(EV_ZQ, mem_ba, mem_addr);
      else if ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} != 4'b0111)
        chk(1'b0, "R10", "illegal bus code", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'b0111);
      if (init_done !== p_done) observe(init_done ? EV_DONE_RISE : EV_DONE_FALL, 3'd0, 16'h0);
    end
    p_rst  = mem_rst_n;
    p_cke  = mem_cke;
    p_done = init_done;
  end

  // Driver: pulses start and queues the expected events of the run.
  task automatic launch(input logic [15:0] m0, input logic [15:0] m1,
                        input logic [15:0] m2, input logic [15:0] m3,
                        input bit rst_hi, input bit cke_hi, input bit done_hi,
                        input int upto);
    longint s, rr, cr, c1, z;
    @(negedge clk);
    #1;
    s = cyc + 1;
    mr0_cfg = m0; mr1_cfg = m1; mr2_cfg = m2; mr3_cfg = m3;
    start = 1'b1;
    if (rst_hi)  push(EV_RST_FALL, s, 3'd0, 16'h0, "R11");
    if (cke_hi)  push(EV_CKE_FALL, s, 3'd0, 16'h0, "R11");
    if (done_hi) push(EV_DONE_FALL, s, 3'd0, 16'h0, "R11");
    rr = s + P_RST;
    cr = rr + E_CKEW;
    c1 = cr + E_XPR;
    z  = c1 + 3 * P_MRD + P_MOD;
    if (upto > 0) push(EV_RST_RISE, rr, 3'd0, 16'h0, "R2");
    if (upto > 1) push(EV_CKE_RISE, cr, 3'd0, 16'h0, "R3");
    if (upto > 2) push(EV_MRS, c1, 3'd2, m2, "R6");
    if (upto > 3) push(EV_MRS, c1 + P_MRD, 3'd3, m3, "R7");
    if (upto > 4) push(EV_MRS, c1 + 2 * P_MRD, 3'd1, m1 & 16'hFFFE, "R8");
    if (upto > 5) push(EV_MRS, c1 + 3 * P_MRD, 3'd0, m0 | 16'h0100, "R8");
    if (upto > 6) push(EV_ZQ, z, 3'd0, 16'h0400, "R9");
    if (upto > 7) push(EV_DONE_RISE, z + E_FIN, 3'd0, 16'h0, "R10");
    @(negedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL R10 watchdog: actual not done expected done");
      finish_up();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(mem_rst_n === 1'b0, "R1", "mem_rst_n in reset", mem_rst_n, 0);
    chk(mem_cke === 1'b0, "R1", "mem_cke in reset", mem_cke, 0);
    chk(init_done === 1'b0, "R1", "init_done in reset", init_done, 0);
    chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} === 4'b0111, "R1", "bus in reset",
        {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'b0111);
    chk(mem_odt === 1'b0, "R5", "odt in reset", mem_odt, 0);
    #1 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(mem_rst_n === 1'b0 && mem_cke === 1'b0 && init_done === 1'b0, "R1",
        "idle pins without start", {mem_rst_n, mem_cke, init_done}, 0);
    mon_en = 1'b1;
    repeat (5) @(negedge clk);

    // Run A: configuration already has DLL bits in their final state.
    launch(16'h0514, 16'h0044, 16'h0018, 16'h0004, 1'b0, 1'b0, 1'b0, 8);
    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);
    chk(init_done === 1'b1, "R10", "done held after run A", init_done, 1);
    chk(mem_cke === 1'b1, "R4", "cke held after run A", mem_cke, 1);

    // Run B from ready: DLL bits arrive opposite and must be forced.
    launch(16'h0a30, 16'h0047, 16'h0208, 16'h0003, 1'b1, 1'b1, 1'b1, 8);
    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);
    chk(init_done === 1'b1, "R10", "done held after run B", init_done, 1);

    // Run C aborted after the second write, then run D from mid-sequence (R11).
    launch(16'h0100, 16'h0001, 16'h0010, 16'h0002, 1'b1, 1'b1, 1'b1, 4);
    repeat (39) @(negedge clk);
    chk(init_done === 1'b0, "R11", "done low during run C", init_done, 0);
    launch(16'h1234, 16'h0f0f, 16'h00f8, 16'h0001, 1'b1, 1'b1, 1'b0, 8);
    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);

    chk(exp_q.size() == 0, "R7", "pending expected events", exp_q.size(), 0);
    chk(!odt_bad, "R5", "odt ever high", odt_bad, 0);
    chk(init_done === 1'b1, "R10", "done held after run D", init_done, 1);
    finish_up();
  end

endmodule